// File: doc/BRIEF.md
# Traversal Sub-Stage Ray Router

This block moves ray tokens between three traversal sub-stages: node fetch (which also decides leaf or inner), box test, and stack operation. Each sub-stage has its own input FIFO. After each stage, a ray goes straight to the FIFO of the stage it needs next. A ray therefore never passes through a stage that has no work for it.

Only the legal transitions are wired; the crossbar is not fully connected. A leaf ray leaves through the intersection exit. When intersection is done, the ray comes back through a return port into the stack stage. A ray whose stack is empty leaves through the shader exit. The sub-stages are fixed-latency stubs that compute their result from fields carried in the token. The pattern field stands in for the sequence of node types the ray will meet, and the count field stands in for the stack depth.

A ray token is `{id[3:0], cnt[2:0], pat[7:0]}`, with `pat` in the low bits. Every port is a valid/ready pair: a transfer happens on a rising clock edge when valid and ready are both high. The outputs depend only on registers.

Top module: `trv_route_fabric`

## Requirements
- R1: After reset, `ist_valid` and `shd_valid` are low, and `new_ready` and `ret_ready` are high.
- R2: The fetch stage shifts `pat` right by one. If the old `pat[0]` was 1, the ray leaves on the intersection exit with `cnt` and `id` unchanged, and it skips the box and stack stages. If the old `pat[0]` was 0, the ray goes to the box stage and from there to the stack stage, unchanged by the box stage.
- R3: If `cnt` is 0 when a ray reaches the stack stage, the ray leaves on the shader exit unchanged. Otherwise the stack stage decrements `cnt` and sends the ray back to the fetch stage.
- R4: A ray accepted on the return port enters the stack stage, and then follows R3.
- R5: Each stage has a latency of LAT cycles. On an idle fabric, a new ray with `pat[0]`=1 is presented on the intersection exit LAT clock edges after the edge that accepted it.
- R6: While an exit is valid and not ready, it stays valid and its token does not change.
- R7: No token is dropped or duplicated. Every accepted ray leaves the shader exit exactly once, and no FIFO is written while full or read while empty.
- R8: When a fed-back ray and an outside ray target the same FIFO in the same cycle, the fed-back ray wins. The stack-to-fetch path beats `new_*`, and the box-to-stack path beats `ret_*`. With no more than 16 rays in flight, all rays complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| new_valid | input | 1 | A new ray is offered |
| new_ready | output | 1 | The fetch FIFO accepts the new ray |
| new_ray | input | 15 | New ray token |
| ret_valid | input | 1 | A ray is returning from intersection |
| ret_ready | output | 1 | The stack FIFO accepts the returning ray |
| ret_ray | input | 15 | Returning ray token |
| ist_valid | output | 1 | A leaf ray is offered to intersection |
| ist_ready | input | 1 | Intersection takes the ray |
| ist_ray | output | 15 | Leaf ray token |
| shd_valid | output | 1 | A finished ray is offered to the shader |
| shd_ready | input | 1 | The shader takes the ray |
| shd_ray | output | 15 | Finished ray token |

## Verification
The hardest state to reach from the ports is a collision, where a fed-back ray and an outside ray compete for the same FIFO. A second hard state is an exit held stalled while rays keep circulating. The stimulus builds both up in two ways. It sends bursts of sixteen rays while both exits are ready only part of the time, so feedback and new arrivals overlap. It also blocks both exits completely for a stretch and then releases them. A scoreboard works out each ray's route from its pattern and count, and it checks every exit token and that every ray finishes.

// File: rtl/trv_pkg.sv
package trv_pkg;
  localparam int ID_W  = 4;
  localparam int CNT_W = 3;
  localparam int PAT_W = 8;

  typedef struct packed {
    logic [ID_W-1:0]  id;
    logic [CNT_W-1:0] cnt;
    logic [PAT_W-1:0] pat;
  } ray_t;

  localparam int RAY_W = $bits(ray_t);

  typedef enum logic [1:0] {ST_FETCH = 2'd0, ST_BOX = 2'd1, ST_STACK = 2'd2} stage_e;

  // 1 selects the stage's alternate route: fetch -> intersection, stack -> shader
  function automatic logic route_alt(stage_e kind, ray_t r);
    case (kind)
      ST_FETCH: route_alt = r.pat[0];
      ST_STACK: route_alt = (r.cnt == '0);
      default:  route_alt = 1'b0;
    endcase
  endfunction

  function automatic ray_t stage_xform(stage_e kind, ray_t r);
    ray_t o;
    o = r;
    case (kind)
      ST_FETCH: o.pat = r.pat >> 1;
      ST_STACK: if (r.cnt != '0) o.cnt = r.cnt - 1'b1;
      default:  o = r;
    endcase
    stage_xform = o;
  endfunction
endpackage

// File: rtl/trv_fifo.sv
module trv_fifo #(
  parameter int W     = 15,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;

  assign full  = (count == (AW+1)'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rd_ptr];

  function automatic logic [AW-1:0] ptr_next(logic [AW-1:0] p);
    ptr_next = (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);  // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);  // R7
endmodule

// File: rtl/trv_stage.sv
module trv_stage
  import trv_pkg::*;
#(
  parameter stage_e KIND = ST_FETCH,
  parameter int     LAT  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  ray_t in_ray,
  output logic in_pop,
  output logic out_valid,
  output ray_t out_ray,
  output logic out_alt,
  input  logic out_ready
);
  logic [LAT-1:0] vld;
  logic [LAT-1:0] alt;
  ray_t           pipe [LAT];
  logic           adv;

  // the whole stub pipe stalls only when its last slot cannot leave
  assign adv    = !(vld[LAT-1] && !out_ready);
  assign in_pop = adv && in_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
    end else if (adv) begin
      vld[0] <= in_valid;
      for (int i = 1; i < LAT; i++) vld[i] <= vld[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      pipe[0] <= stage_xform(KIND, in_ray);
      alt[0]  <= route_alt(KIND, in_ray);
      for (int i = 1; i < LAT; i++) begin
        pipe[i] <= pipe[i-1];
        alt[i]  <= alt[i-1];
      end
    end
  end

  assign out_valid = vld[LAT-1];
  assign out_ray   = pipe[LAT-1];
  assign out_alt   = alt[LAT-1];

  AST_STAGE_KEEPS_RAY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);  // R7
endmodule

// File: rtl/trv_route_fabric.sv
module trv_route_fabric
  import trv_pkg::*;
#(
  parameter int LAT   = 2,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             new_valid,
  output logic             new_ready,
  input  logic [RAY_W-1:0] new_ray,
  input  logic             ret_valid,
  output logic             ret_ready,
  input  logic [RAY_W-1:0] ret_ray,
  output logic             ist_valid,
  input  logic             ist_ready,
  output logic [RAY_W-1:0] ist_ray,
  output logic             shd_valid,
  input  logic             shd_ready,
  output logic [RAY_W-1:0] shd_ray
);
  localparam int NST = 3;
  localparam int FE  = 0;
  localparam int BX  = 1;
  localparam int SK  = 2;

  logic [NST-1:0] f_push, f_full, f_empty, f_pop;
  ray_t           f_din  [NST];
  ray_t           f_dout [NST];
  logic [NST-1:0] so_valid, so_alt, so_ready;
  ray_t           so_ray [NST];

  // named crossbar events (only the legal branch paths exist)
  logic fb_to_fetch, done_to_shd, leaf_to_ist, inner_to_box, box_to_stack;
  logic new_to_fetch, ret_to_stack;

  assign fb_to_fetch  = so_valid[SK] && !so_alt[SK];
  assign done_to_shd  = so_valid[SK] &&  so_alt[SK];
  assign leaf_to_ist  = so_valid[FE] &&  so_alt[FE];
  assign inner_to_box = so_valid[FE] && !so_alt[FE];
  assign box_to_stack = so_valid[BX];

  // fed-back rays win over rays arriving from outside
  assign new_ready    = !f_full[FE] && !fb_to_fetch;
  assign ret_ready    = !f_full[SK] && !box_to_stack;
  assign new_to_fetch = new_valid && new_ready;
  assign ret_to_stack = ret_valid && ret_ready;

  assign f_push[FE] = (fb_to_fetch && !f_full[FE]) || new_to_fetch;
  assign f_din[FE]  = fb_to_fetch ? so_ray[SK] : ray_t'(new_ray);
  assign f_push[BX] = inner_to_box && !f_full[BX];
  assign f_din[BX]  = so_ray[FE];
  assign f_push[SK] = (box_to_stack && !f_full[SK]) || ret_to_stack;
  assign f_din[SK]  = box_to_stack ? so_ray[BX] : ray_t'(ret_ray);

  assign so_ready[FE] = so_alt[FE] ? ist_ready : !f_full[BX];
  assign so_ready[BX] = !f_full[SK];
  assign so_ready[SK] = so_alt[SK] ? shd_ready : !f_full[FE];

  for (genvar g = 0; g < NST; g++) begin : g_sub
    trv_fifo #(.W(RAY_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (f_push[g]),
      .din   (f_din[g]),
      .full  (f_full[g]),
      .pop   (f_pop[g]),
      .dout  (f_dout[g]),
      .empty (f_empty[g])
    );
    trv_stage #(.KIND(stage_e'(g)), .LAT(LAT)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (!f_empty[g]),
      .in_ray    (f_dout[g]),
      .in_pop    (f_pop[g]),
      .out_valid (so_valid[g]),
      .out_ray   (so_ray[g]),
      .out_alt   (so_alt[g]),
      .out_ready (so_ready[g])
    );
  end

  assign ist_valid = leaf_to_ist;
  assign ist_ray   = so_ray[FE];
  assign shd_valid = done_to_shd;
  assign shd_ray   = so_ray[SK];

  AST_FEEDBACK_BEATS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    fb_to_fetch |-> !new_ready);  // R8
  AST_BOX_BEATS_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    box_to_stack |-> !ret_ready);  // R8
  AST_IST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ist_valid && !ist_ready |=> ist_valid && $stable(ist_ray));  // R6
  AST_SHD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    shd_valid && !shd_ready |=> shd_valid && $stable(shd_ray));  // R6
  AST_SHD_STACK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    shd_valid |-> (shd_ray[PAT_W +: CNT_W] == '0));  // R3
endmodule

// File: tb/sim_trv_route_fabric.sv
module sim_trv_route_fabric;
  import trv_pkg::*;
  localparam int LAT = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic new_valid, new_ready, ret_valid, ret_ready;
  logic ist_valid, ist_ready, shd_valid, shd_ready;
  logic [RAY_W-1:0] new_ray, ret_ray, ist_ray, shd_ray;

  trv_route_fabric #(.LAT(LAT), .DEPTH(16)) u0 (
    .clk(clk), .rst_n(rst_n),
    .new_valid(new_valid), .new_ready(new_ready), .new_ray(new_ray),
    .ret_valid(ret_valid), .ret_ready(ret_ready), .ret_ray(ret_ray),
    .ist_valid(ist_valid), .ist_ready(ist_ready), .ist_ray(ist_ray),
    .shd_valid(shd_valid), .shd_ready(shd_ready), .shd_ray(shd_ray)
  );

  int checks = 0, errors = 0;
  int cyc = 0, rdy_pct = 100;
  int sent_cnt = 0, done_cnt = 0;
  logic [RAY_W-1:0] new_q[$];
  logic [RAY_W-1:0] ret_q[$];
  int               exp_kind [16];
  logic [RAY_W-1:0] exp_tok  [16];
  bit               via_ret  [16];
  bit lat_arm = 0;
  int acc_cyc = 0;
  bit p_ist_stall = 0, p_shd_stall = 0;
  logic [RAY_W-1:0] p_ist_tok, p_shd_tok;

  function automatic logic [RAY_W-1:0] mk(int id, int cnt, int pat);
    return {id[ID_W-1:0], cnt[CNT_W-1:0], pat[PAT_W-1:0]};
  endfunction
  function automatic int t_id(logic [RAY_W-1:0] t);
    return int'(t[RAY_W-1 -: ID_W]);
  endfunction

  // expected exit for a ray entering the fetch stage (kind 0 = intersection, 1 = shader)
  task automatic walk_fetch(input logic [RAY_W-1:0] t, output int k, output logic [RAY_W-1:0] o);
    int c = int'(t[PAT_W +: CNT_W]);
    logic [PAT_W-1:0] p = t[PAT_W-1:0];
    k = -1;
    for (int i = 0; i < 64 && k < 0; i++) begin
      logic leaf = p[0];
      p = {1'b0, p[PAT_W-1:1]};
      if (leaf) k = 0;
      else if (c == 0) k = 1;
      else c = c - 1;
    end
    o = mk(t_id(t), c, int'(p));
  endtask

  task automatic walk_stack(input logic [RAY_W-1:0] t, output int k, output logic [RAY_W-1:0] o);
    int c = int'(t[PAT_W +: CNT_W]);
    if (c == 0) begin k = 1; o = t; end
    else walk_fetch(mk(t_id(t), c - 1, int'(t[PAT_W-1:0])), k, o);
  endtask

  task automatic check(input bit ok, input string req, input logic [RAY_W-1:0] act, input logic [RAY_W-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic send(input int id, input int cnt, input int pat);
    logic [RAY_W-1:0] t = mk(id, cnt, pat);
    walk_fetch(t, exp_kind[id], exp_tok[id]);
    via_ret[id] = 0;
    new_q.push_back(t);
    sent_cnt++;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", done_cnt, sent_cnt);
      finish_run();
    end
    ist_ready = (($urandom % 100) < rdy_pct);
    shd_ready = (($urandom % 100) < rdy_pct);
    new_valid = (new_q.size() > 0);
    new_ray   = new_valid ? new_q[0] : '0;
    ret_valid = (ret_q.size() > 0);
    ret_ray   = ret_valid ? ret_q[0] : '0;
    #1;
    if (p_ist_stall) check(ist_valid && ist_ray == p_ist_tok, "R6 ist hold", ist_ray, p_ist_tok);
    if (p_shd_stall) check(shd_valid && shd_ray == p_shd_tok, "R6 shd hold", shd_ray, p_shd_tok);
    p_ist_stall = ist_valid && !ist_ready; p_ist_tok = ist_ray;
    p_shd_stall = shd_valid && !shd_ready; p_shd_tok = shd_ray;
    if (lat_arm && ist_valid) begin
      check(cyc - acc_cyc == LAT + 1, "R5 latency", RAY_W'(cyc - acc_cyc), RAY_W'(LAT + 1));
      lat_arm = 0;
    end
    if (ist_valid && ist_ready) begin
      int id = t_id(ist_ray);
      check(exp_kind[id] == 0 && ist_ray == exp_tok[id], "R2 leaf exit", ist_ray, exp_tok[id]);
      walk_stack(ist_ray, exp_kind[id], exp_tok[id]);
      via_ret[id] = 1;
      ret_q.push_back(ist_ray);
    end
    if (shd_valid && shd_ready) begin
      int id = t_id(shd_ray);
      check(exp_kind[id] == 1 && shd_ray == exp_tok[id],
            via_ret[id] ? "R4 R3 finish after return" : "R3 finish", shd_ray, exp_tok[id]);
      exp_kind[id] = 2;
      done_cnt++;
    end
    if (new_valid && new_ready) begin
      void'(new_q.pop_front());
    end
    if (ret_valid && ret_ready) void'(ret_q.pop_front());
  endtask

  task automatic run_all();
    while (done_cnt < sent_cnt || new_q.size() > 0) step();
  endtask

  initial begin
    rst_n = 0; new_valid = 0; ret_valid = 0; ist_ready = 0; shd_ready = 0;
    new_ray = '0; ret_ray = '0;
    for (int i = 0; i < 16; i++) begin exp_kind[i] = 2; exp_tok[i] = '0; via_ret[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check(!ist_valid, "R1 ist_valid", RAY_W'(ist_valid), '0);
    check(!shd_valid, "R1 shd_valid", RAY_W'(shd_valid), '0);
    check(new_ready,  "R1 new_ready", RAY_W'(new_ready), 1);
    check(ret_ready,  "R1 ret_ready", RAY_W'(ret_ready), 1);

    // leaf on first fetch: latency then return path
    rdy_pct = 100;
    send(0, 0, 8'b0000_0001);
    acc_cyc = cyc + 1; lat_arm = 1;
    run_all();
    check(!lat_arm, "R5 latency seen", RAY_W'(lat_arm), '0);

    // directed patterns
    send(1, 0, 8'h00);
    send(2, 2, 8'b0000_0100);
    send(3, 7, 8'hFF);
    send(4, 5, 8'hA5);
    send(5, 3, 8'h00);
    run_all();

    // load with partial exit readiness
    rdy_pct = 35;
    for (int i = 0; i < 16; i++) send(i, $urandom % 8, $urandom % 256);
    run_all();
    check(done_cnt == sent_cnt, "R7 R8 all rays finished", RAY_W'(done_cnt), RAY_W'(sent_cnt));

    // exits fully blocked, then released
    rdy_pct = 0;
    for (int i = 0; i < 16; i++) send(i, $urandom % 8, 8'h55 ^ i);
    repeat (80) step();
    check(done_cnt == sent_cnt - 16, "R6 nothing leaves while blocked", RAY_W'(done_cnt), RAY_W'(sent_cnt - 16));
    rdy_pct = 100;
    run_all();
    check(done_cnt == sent_cnt, "R7 R8 drain after block", RAY_W'(done_cnt), RAY_W'(sent_cnt));
    repeat (10) step();
    check(!ist_valid && !shd_valid, "R7 no duplicate exits", RAY_W'({ist_valid, shd_valid}), '0);
    finish_run();
  end
endmodule